// File: doc/BRIEF.md
# In-Order Dual Overlapping Execution Units

This block is a cycle-accurate timing model of an in-order issue stage that feeds two functional units with nested capabilities. There is no buffering between issue and execution. The first unit executes a subset of the instruction classes that the second unit executes. Instructions arrive one at a time on a valid/ready stream. Each instruction carries three things: a class code, a latency, and an optional tag that names an older producer instruction. Each instruction is placed on a capable unit that is free in the current cycle. The first unit is chosen whenever it can serve the instruction and is free.

For every accepted instruction the block reports its sequence number, the unit it received, its entry cycle and its release cycle. After the final instruction has been accepted and every unit has drained, the block raises a done flag and gives the total execution time. The model exists to study how a change in one latency can move later instructions onto a different unit. This can change the total time by more than the latency change itself, even though every allocation happens in program order.

Top module: `ovl_issue_pair`

## Requirements
- R1: After reset the cycle counter is zero. `rpt_valid` and `done` are low. With the input stream idle and a class that only the second unit can run, `in_ready` is high. An instruction offered in the first cycle after reset enters at cycle 0.
- R2: A class code whose bit 3 is 0 (4-bit code) is executed only by the second unit, reported as `rpt_unit` = 1. Such an instruction waits while the second unit is busy, even when the first unit is free.
- R3: A class code whose bit 3 is 1 goes to the first unit (`rpt_unit` = 0) when that unit is free. If only the second unit is free, the instruction goes to the second unit (`rpt_unit` = 1).
- R4: At most one instruction is accepted per cycle, in program order. A head instruction that cannot issue blocks every younger instruction, even one whose unit is free.
- R5: A unit holds one instruction at a time. The release cycle equals the entry cycle plus the latency, and a latency of 0 counts as 1. The unit can accept a new instruction in its release cycle.
- R6: An instruction with `in_dep_en` high is not accepted before the release cycle of the instruction whose sequence number is `in_dep_id`. It may enter in that release cycle.
- R7: One cycle after an instruction is accepted, `rpt_valid` is high for one cycle. `rpt_id`, `rpt_unit`, `rpt_class`, `rpt_entry` and `rpt_release` describe that instruction. Sequence numbers start at 0 after reset.
- R8: The instruction flagged `in_last` (or the one with sequence number MAX_INSTR-1) closes the stream, and `in_ready` stays low afterwards. `done` rises once the cycle counter reaches the largest release cycle, and `total_cycles` then equals that cycle. `done` stays high until reset.
- R9: When a latency change moves a later instruction onto the other unit, the total time follows the new allocation. For example, raising the first instruction's latency from 1 to 2 in the sequence (first-unit class lat 1, first-unit class lat 4, second-unit class lat 4) raises the total from 6 to 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Head instruction present |
| in_ready | output | 1 | Head instruction can be accepted this cycle |
| in_class | input | CLS_W | Class code; top bit set means the first unit can run it |
| in_lat | input | LAT_W | Latency in cycles (0 treated as 1) |
| in_dep_en | input | 1 | Instruction depends on an older producer |
| in_dep_id | input | ID_W | Sequence number of that producer |
| in_last | input | 1 | Final instruction of the stream |
| rpt_valid | output | 1 | Report fields valid |
| rpt_id | output | ID_W | Sequence number of the reported instruction |
| rpt_unit | output | 1 | 0 = first unit, 1 = second unit |
| rpt_class | output | CLS_W | Class code of the reported instruction |
| rpt_entry | output | CYC_W | Entry cycle |
| rpt_release | output | CYC_W | Release cycle |
| done | output | 1 | All instructions have released their units |
| total_cycles | output | CYC_W | Total execution time |

## Verification
The bound checker enforces several rules on every cycle: no two units are taken in one cycle, a busy unit is never taken, second-unit-only classes land on the second unit, and the first unit wins whenever it is free. It also checks that each report's entry equals the acceptance cycle and that its release exceeds the entry by the latency, and that done is sticky and closes the input. The rest depends on whole sequences, so only the directed scenarios can show it. This covers head-of-line blocking behind a busy unit, waiting on a producer until its release cycle, the exact total time, and a one-cycle latency increase that moves an instruction to the other unit and adds three cycles.

// File: rtl/ovl_pkg.sv
`timescale 1ns/1ps
package ovl_pkg;
  typedef enum logic {
    UNIT_FIRST  = 1'b0,
    UNIT_SECOND = 1'b1
  } unit_e;

  localparam int NUM_UNITS = 2;
endpackage

// File: rtl/ovl_unit_slot.sv
`timescale 1ns/1ps
module ovl_unit_slot #(
  parameter int CYC_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CYC_W-1:0] now,
  input  logic             take,
  input  logic [CYC_W-1:0] rel_in,
  output logic             free
);
  logic             busy_q;
  logic [CYC_W-1:0] rel_q;

  // free when idle or when the held instruction releases in this cycle
  assign free = !busy_q || (rel_q == now);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      rel_q  <= '0;
    end else if (take) begin
      busy_q <= 1'b1;
      rel_q  <= rel_in;
    end else if (busy_q && rel_q == now) begin
      busy_q <= 1'b0;
    end
  end
endmodule

// File: rtl/ovl_issue_select.sv
`timescale 1ns/1ps
module ovl_issue_select
  import ovl_pkg::*;
(
  input  logic  in_valid,
  input  logic  stopped,
  input  logic  cap_first,
  input  logic  free_first,
  input  logic  free_second,
  input  logic  dep_ok,
  output logic  ready,
  output logic  fire,
  output unit_e pick,
  output logic  take_first,
  output logic  take_second
);
  logic unit_ok;

  always_comb begin
    if (cap_first) begin
      unit_ok = free_first || free_second;
      pick    = free_first ? UNIT_FIRST : UNIT_SECOND;
    end else begin
      unit_ok = free_second;
      pick    = UNIT_SECOND;
    end
  end

  assign ready       = !stopped && dep_ok && unit_ok;
  assign fire        = in_valid && ready;
  assign take_first  = fire && (pick == UNIT_FIRST);
  assign take_second = fire && (pick == UNIT_SECOND);
endmodule

// File: rtl/ovl_rel_table.sv
`timescale 1ns/1ps
module ovl_rel_table #(
  parameter int DEPTH = 16,
  parameter int CYC_W = 16,
  localparam int ID_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [ID_W-1:0]  waddr,
  input  logic [CYC_W-1:0] wdata,
  input  logic [ID_W-1:0]  raddr,
  output logic             rvalid,
  output logic [CYC_W-1:0] rdata
);
  logic [CYC_W-1:0] mem [DEPTH];
  logic [DEPTH-1:0] vld_q;

  // release-time storage, no reset, so it maps to distributed RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)     vld_q <= '0;
    else if (we) vld_q[waddr] <= 1'b1;
  end

  assign rdata  = mem[raddr];
  assign rvalid = vld_q[raddr];
endmodule

// File: rtl/ovl_issue_pair.sv
`timescale 1ns/1ps
module ovl_issue_pair
  import ovl_pkg::*;
#(
  parameter int CLS_W     = 4,
  parameter int LAT_W     = 4,
  parameter int CYC_W     = 16,
  parameter int MAX_INSTR = 16,
  localparam int ID_W     = $clog2(MAX_INSTR),
  localparam int CAP_BIT  = CLS_W - 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [CLS_W-1:0] in_class,
  input  logic [LAT_W-1:0] in_lat,
  input  logic             in_dep_en,
  input  logic [ID_W-1:0]  in_dep_id,
  input  logic             in_last,
  output logic             rpt_valid,
  output logic [ID_W-1:0]  rpt_id,
  output logic             rpt_unit,
  output logic [CLS_W-1:0] rpt_class,
  output logic [CYC_W-1:0] rpt_entry,
  output logic [CYC_W-1:0] rpt_release,
  output logic             done,
  output logic [CYC_W-1:0] total_cycles
);
  logic [CYC_W-1:0] now_q;
  logic [ID_W-1:0]  id_q;
  logic             stopped_q;
  logic [CYC_W-1:0] max_rel_q;
  logic             done_q;
  logic [CYC_W-1:0] total_q;

  logic [CYC_W-1:0] lat_eff;
  logic [CYC_W-1:0] rel_new;
  logic             dep_vld;
  logic [CYC_W-1:0] dep_rel;
  logic             dep_ok;
  logic             fire;
  unit_e            pick;
  logic             take_a, take_b;
  logic             free_a, free_b;
  logic [NUM_UNITS-1:0] take_vec, free_vec;

  assign lat_eff = (in_lat == '0) ? CYC_W'(1) : CYC_W'(in_lat);
  assign rel_new = now_q + lat_eff;

  ovl_rel_table #(.DEPTH(MAX_INSTR), .CYC_W(CYC_W)) u_table (
    .clk    (clk),
    .rst    (rst),
    .we     (fire),
    .waddr  (id_q),
    .wdata  (rel_new),
    .raddr  (in_dep_id),
    .rvalid (dep_vld),
    .rdata  (dep_rel)
  );

  assign dep_ok = !in_dep_en || (dep_vld && (dep_rel <= now_q));

  ovl_issue_select u_sel (
    .in_valid    (in_valid),
    .stopped     (stopped_q),
    .cap_first   (in_class[CAP_BIT]),
    .free_first  (free_a),
    .free_second (free_b),
    .dep_ok      (dep_ok),
    .ready       (in_ready),
    .fire        (fire),
    .pick        (pick),
    .take_first  (take_a),
    .take_second (take_b)
  );

  assign take_vec = {take_b, take_a};

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    ovl_unit_slot #(.CYC_W(CYC_W)) u_slot (
      .clk    (clk),
      .rst    (rst),
      .now    (now_q),
      .take   (take_vec[u]),
      .rel_in (rel_new),
      .free   (free_vec[u])
    );
  end

  assign free_a = free_vec[0];
  assign free_b = free_vec[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      now_q     <= '0;
      id_q      <= '0;
      stopped_q <= 1'b0;
      max_rel_q <= '0;
      done_q    <= 1'b0;
      total_q   <= '0;
    end else begin
      now_q <= now_q + 1'b1;
      if (fire) begin
        id_q <= id_q + 1'b1;
        if (in_last || id_q == ID_W'(MAX_INSTR - 1)) stopped_q <= 1'b1;
        if (rel_new > max_rel_q) max_rel_q <= rel_new;
      end
      if (stopped_q && !done_q && now_q >= max_rel_q) begin
        done_q  <= 1'b1;
        total_q <= max_rel_q;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rpt_valid   <= 1'b0;
      rpt_id      <= '0;
      rpt_unit    <= 1'b0;
      rpt_class   <= '0;
      rpt_entry   <= '0;
      rpt_release <= '0;
    end else begin
      rpt_valid <= fire;
      if (fire) begin
        rpt_id      <= id_q;
        rpt_unit    <= pick;
        rpt_class   <= in_class;
        rpt_entry   <= now_q;
        rpt_release <= rel_new;
      end
    end
  end

  assign done         = done_q;
  assign total_cycles = total_q;
endmodule

// File: rtl/ovl_issue_pair_chk.sv
`timescale 1ns/1ps
module ovl_issue_pair_chk #(
  parameter int LAT_W = 4,
  parameter int CYC_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             fire,
  input logic             cap,
  input logic [LAT_W-1:0] in_lat,
  input logic             in_ready,
  input logic             take_a,
  input logic             take_b,
  input logic             free_a,
  input logic             free_b,
  input logic [CYC_W-1:0] now_q,
  input logic             rpt_valid,
  input logic             rpt_unit,
  input logic [CYC_W-1:0] rpt_entry,
  input logic [CYC_W-1:0] rpt_release,
  input logic             done
);
  AST_AT_MOST_ONE_TAKE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({take_a, take_b})); // R4
  AST_SECOND_ONLY_CLASS: assert property (@(posedge clk) disable iff (rst)
    (fire && !cap) |=> (rpt_unit == 1'b1)); // R2
  AST_FIRST_PREFERRED: assert property (@(posedge clk) disable iff (rst)
    (fire && cap && free_a) |=> (rpt_unit == 1'b0)); // R3
  AST_FIRST_NOT_WHEN_BUSY: assert property (@(posedge clk) disable iff (rst)
    take_a |-> free_a); // R5
  AST_SECOND_NOT_WHEN_BUSY: assert property (@(posedge clk) disable iff (rst)
    take_b |-> free_b); // R5
  AST_ENTRY_IS_ACCEPT_CYCLE: assert property (@(posedge clk) disable iff (rst)
    fire |=> (rpt_valid && rpt_entry == $past(now_q))); // R7
  AST_RELEASE_ADDS_LATENCY: assert property (@(posedge clk) disable iff (rst)
    (fire && in_lat != '0) |=> ((rpt_release - rpt_entry) == CYC_W'($past(in_lat)))); // R5
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
    done |=> done); // R8
  AST_CLOSED_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
    done |-> !in_ready); // R8
endmodule

bind ovl_issue_pair ovl_issue_pair_chk #(.LAT_W(LAT_W), .CYC_W(CYC_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .fire        (fire),
  .cap         (in_class[CAP_BIT]),
  .in_lat      (in_lat),
  .in_ready    (in_ready),
  .take_a      (take_a),
  .take_b      (take_b),
  .free_a      (free_a),
  .free_b      (free_b),
  .now_q       (now_q),
  .rpt_valid   (rpt_valid),
  .rpt_unit    (rpt_unit),
  .rpt_entry   (rpt_entry),
  .rpt_release (rpt_release),
  .done        (done)
);

// File: tb/ovl_issue_pair_tb.sv
`timescale 1ns/1ps
module ovl_issue_pair_tb;
  localparam int CLS_W = 4, LAT_W = 4, CYC_W = 16, MAX_INSTR = 16;
  localparam int ID_W = $clog2(MAX_INSTR);
  localparam logic [3:0] CA = 4'b1010;  // first-unit capable
  localparam logic [3:0] CB = 4'b0101;  // second unit only

  logic clk = 1'b0, rst = 1'b1;
  logic in_valid = 1'b0, in_dep_en = 1'b0, in_last = 1'b0;
  logic [CLS_W-1:0] in_class = '0;
  logic [LAT_W-1:0] in_lat = '0;
  logic [ID_W-1:0]  in_dep_id = '0;
  logic in_ready, rpt_valid, rpt_unit, done;
  logic [ID_W-1:0]  rpt_id;
  logic [CLS_W-1:0] rpt_class;
  logic [CYC_W-1:0] rpt_entry, rpt_release, total_cycles;

  int checks = 0, fails = 0;
  int g_unit [MAX_INSTR];
  int g_entry[MAX_INSTR];
  int g_rel  [MAX_INSTR];

  always #2.5 clk = ~clk;

  ovl_issue_pair #(.CLS_W(CLS_W), .LAT_W(LAT_W), .CYC_W(CYC_W), .MAX_INSTR(MAX_INSTR)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_class(in_class), .in_lat(in_lat), .in_dep_en(in_dep_en),
    .in_dep_id(in_dep_id), .in_last(in_last), .rpt_valid(rpt_valid),
    .rpt_id(rpt_id), .rpt_unit(rpt_unit), .rpt_class(rpt_class),
    .rpt_entry(rpt_entry), .rpt_release(rpt_release), .done(done),
    .total_cycles(total_cycles)
  );

  always @(negedge clk) begin
    if (!rst && rpt_valid) begin
      g_unit[rpt_id]  = int'(rpt_unit);
      g_entry[rpt_id] = int'(rpt_entry);
      g_rel[rpt_id]   = int'(rpt_release);
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; in_valid = 1'b0; in_last = 1'b0; in_dep_en = 1'b0;
    in_class = '0; in_lat = '0; in_dep_id = '0;
    for (int i = 0; i < MAX_INSTR; i++) begin
      g_unit[i] = -1; g_entry[i] = -1; g_rel[i] = -1;
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic send(input logic [3:0] cls, input int lat, input logic dep,
                      input int dep_id, input logic last);
    in_valid = 1'b1; in_class = cls; in_lat = LAT_W'(lat);
    in_dep_en = dep; in_dep_id = ID_W'(dep_id); in_last = last;
    #1;
    while (!in_ready) begin
      @(negedge clk); #1;
    end
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0; in_dep_en = 1'b0;
  endtask

  task automatic wait_done(input string req, input int exp_total);
    int n = 0;
    while (!done && n < 200) begin
      @(negedge clk); n++;
    end
    chk({req, " done"}, int'(done), 1);
    chk({req, " total"}, int'(total_cycles), exp_total);
  endtask

  task automatic t_reset();
    do_reset();
    #1;
    chk("R1 rpt_valid", int'(rpt_valid), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 ready", int'(in_ready), 1);
    send(CA, 2, 1'b0, 0, 1'b1);
    @(negedge clk);
    chk("R1 first entry", g_entry[0], 0);
  endtask

  task automatic t_prefer();
    do_reset();
    send(CA, 3, 1'b0, 0, 1'b0);
    send(CA, 2, 1'b0, 0, 1'b1);
    wait_done("R8 prefer", 3);
    chk("R3 first on unit1", g_unit[0], 0);
    chk("R3 busy first -> unit2", g_unit[1], 1);
    chk("R7 entry id1", g_entry[1], 1);
    chk("R5 release id1", g_rel[1], 3);
  endtask

  task automatic t_second_only();
    do_reset();
    send(CB, 4, 1'b0, 0, 1'b0);
    send(CB, 1, 1'b0, 0, 1'b1);
    wait_done("R8 second-only", 5);
    chk("R2 unit id0", g_unit[0], 1);
    chk("R2 unit id1", g_unit[1], 1);
    chk("R5 entry at release", g_entry[1], 4);
  endtask

  task automatic t_in_order();
    do_reset();
    send(CB, 3, 1'b0, 0, 1'b0);
    send(CB, 1, 1'b0, 0, 1'b0);
    send(CA, 1, 1'b0, 0, 1'b1);
    wait_done("R8 in-order", 5);
    chk("R4 blocked entry", g_entry[2], 4);
    chk("R4 blocked unit", g_unit[2], 0);
  endtask

  task automatic t_dependency();
    do_reset();
    send(CA, 5, 1'b0, 0, 1'b0);
    send(CA, 2, 1'b1, 0, 1'b1);
    wait_done("R8 dependency", 7);
    chk("R6 dependent entry", g_entry[1], 5);
    chk("R6 dependent unit", g_unit[1], 0);
  endtask

  task automatic t_anomaly();
    do_reset();
    send(CA, 1, 1'b0, 0, 1'b0);
    send(CA, 4, 1'b0, 0, 1'b0);
    send(CB, 4, 1'b0, 0, 1'b1);
    wait_done("R9 short", 6);
    chk("R9 short unit id1", g_unit[1], 0);
    do_reset();
    send(CA, 2, 1'b0, 0, 1'b0);
    send(CA, 4, 1'b0, 0, 1'b0);
    send(CB, 4, 1'b0, 0, 1'b1);
    wait_done("R9 long", 9);
    chk("R9 long unit id1", g_unit[1], 1);
    chk("R9 long entry id2", g_entry[2], 5);
  endtask

  task automatic t_zero_lat_and_close();
    do_reset();
    send(CA, 0, 1'b0, 0, 1'b1);
    wait_done("R5 zero latency", 1);
    chk("R5 zero latency release", g_rel[0], 1);
    in_class = CA; in_valid = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk("R8 closed ready", int'(in_ready), 0);
    chk("R8 done sticky", int'(done), 1);
    chk("R8 nothing accepted", g_entry[1], -1);
    in_valid = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    fails++; checks++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_prefer();
    t_second_only();
    t_in_order();
    t_dependency();
    t_anomaly();
    t_zero_lat_and_close();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule